// File: doc/BRIEF.md
# Shared-Port Structural Hazard Stall Controller

This block steers a five-stage in-order pipeline (fetch, decode, execute, memory, write-back) whose instruction fetch and data loads and stores go through one single-port memory. Each cycle it looks at the instruction in the memory stage. If that instruction is a valid load or store, the data access gets the port for that cycle. Fetch is then blocked, the program counter holds, and the IF/ID register takes a bubble whose valid bit is clear. That bubble travels down the pipeline in place of an instruction, so the blocked instruction completes exactly one cycle later. Instructions that do not touch data memory never cost a cycle. Data accesses placed back to back keep pushing the same fetch further out.

Internally the block keeps a shadow of the per-stage valid bits and the load/store class. The decoder reports the class of the instruction in decode, and the shadow carries it to the memory stage under the same stall and flush controls the block drives. A flush input, for a taken branch, clears IF/ID and ID/EX. When a flush and a structural stall fall in the same cycle, the flush wins. The write-back valid bit is brought out, so the pipeline's retirement timing can be seen at the port.

Top module: `ushz_hazard_ctrl`

## Requirements
- R1: While rst_n is low at a clock edge, every shadow valid bit clears, so wb_valid and grant_data read 0 afterwards.
- R2: When the memory-stage instruction is a valid load or store, grant_data=1, addr_sel=1 (data address) and grant_fetch=0, even if fetch_req=1.
- R3: When no valid load or store is in the memory stage and fetch_req=1, grant_fetch=1, addr_sel=0 (program counter address) and pc_en=1 in the same cycle.
- R4: A fetch that is blocked by a data access gives pc_en=0 and ifid_bubble=1, and decode holds no valid instruction in the next cycle.
- R5: An instruction granted fetch in cycle c shows wb_valid in cycle c+4, and instructions retire in fetch order.
- R6: A stream with no loads or stores is fetched and retired at one instruction per cycle, with no stall.
- R7: Each load or store blocks the fetch that would fall three cycles after its own fetch, so the affected fetch moves one cycle later. Consecutive data accesses delay it further.
- R8: flush=1 clears the valid bits loaded into IF/ID and ID/EX at that edge, so the two youngest instructions never reach write-back. pc_en=1 lets the program counter take the redirect.
- R9: When flush=1 and a data access in the memory stage coincide, the flush wins: pc_en=1, ifid_bubble=1, idex_bubble=1 and fetch_stall=0. The data access still holds the port (grant_data=1).
- R10: With fetch_req=0 and no data access, grant_fetch=0, pc_en=0, ifid_bubble=1 and fetch_stall=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_req | input | 1 | Front end wants to fetch this cycle |
| id_is_load | input | 1 | Instruction in decode is a load (ignored when decode is empty) |
| id_is_store | input | 1 | Instruction in decode is a store (ignored when decode is empty) |
| flush | input | 1 | Taken-branch redirect |
| grant_fetch | output | 1 | Memory port given to instruction fetch |
| grant_data | output | 1 | Memory port given to the memory-stage data access |
| addr_sel | output | 1 | Port address select: 0 program counter, 1 data address |
| pc_en | output | 1 | Program counter load enable |
| ifid_en | output | 1 | IF/ID payload load enable |
| ifid_bubble | output | 1 | IF/ID valid bit cleared at this edge |
| idex_bubble | output | 1 | ID/EX valid bit cleared at this edge |
| fetch_stall | output | 1 | A wanted fetch is lost to a data access |
| wb_valid | output | 1 | A valid instruction is in write-back |

## Verification
Grants, address select, enables, bubbles and fetch_stall are combinational. They are due in the same cycle as the inputs and the shadow state that cause them. The bench drives each cycle's inputs on the falling edge and samples 1 ns later. wb_valid comes four register stages after a fetch grant. So for every instruction, the bench computes the expected fetch cycle from the load/store positions in the stream, adds four, and compares that with the cycle in which wb_valid was seen. The flush cases use hand-derived retirement cycles. Their in-cycle control values are sampled in the flush cycle itself.

// File: rtl/ushz_pkg.sv
// Package: shared types for the shared-port hazard controller.
// Assumes: one shadow slot per pipeline register after IF/ID.
package ushz_pkg;

    // One pipeline-register shadow: valid bit plus data-memory class.
    typedef struct packed {
        logic v;
        logic ldst;
    } slot_t;

    // Memory port address source.
    typedef enum logic {
        SEL_PC   = 1'b0,
        SEL_DATA = 1'b1
    } addr_sel_e;

endpackage

// File: rtl/ushz_port_arb.sv
// Module: fixed-priority owner select for the single memory port.
// Assumes: the data access cannot wait, so it always beats fetch.
module ushz_port_arb
    import ushz_pkg::*;
(
    input  logic data_req,
    input  logic fetch_req,
    output logic grant_data,
    output logic grant_fetch,
    output logic addr_sel
);
    addr_sel_e sel;

    // Purpose: give the port to the data access first, fetch otherwise.
    always_comb begin
        grant_data  = data_req;
        grant_fetch = fetch_req & ~data_req;
        sel         = data_req ? SEL_DATA : SEL_PC;
        addr_sel    = sel;
    end
endmodule

// File: rtl/ushz_stage_ctl.sv
// Module: turns the port decision and flush into register controls.
// Assumes: flush outranks a structural stall; the PC takes the redirect.
module ushz_stage_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic grant_fetch,
    input  logic data_req,
    input  logic fetch_req,
    input  logic flush,
    output logic pc_en,
    output logic ifid_en,
    output logic ifid_bubble,
    output logic idex_bubble,
    output logic fetch_stall
);
    // Purpose: derive hold, bubble and stall signals for this cycle.
    always_comb begin
        pc_en       = grant_fetch | flush;
        ifid_en     = grant_fetch & ~flush;
        ifid_bubble = ~grant_fetch | flush;
        idex_bubble = flush;
        fetch_stall = data_req & fetch_req & ~flush;
    end

    // R4: a lost fetch must never advance the program counter.
    assert_stall_holds_pc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_stall |-> (!pc_en && ifid_bubble));
endmodule

// File: rtl/ushz_shadow_pipe.sv
// Module: shadow valid / load-store bits for the stages after fetch.
// Assumes: TAIL covers ID/EX, EX/MEM and MEM/WB; memory stage reads the
//          second-to-last slot, write-back the last.
module ushz_shadow_pipe
    import ushz_pkg::*;
#(
    parameter int TAIL = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ifid_bubble,
    input  logic idex_bubble,
    input  logic id_ldst,
    output logic data_req,
    output logic wb_v
);
    localparam int MEM_IDX = TAIL - 2;
    localparam int WB_IDX  = TAIL - 1;

    logic  ifid_v;
    slot_t tail [TAIL];

    // Purpose: IF/ID valid follows a granted, unflushed fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) ifid_v <= 1'b0;
        else        ifid_v <= ~ifid_bubble;
    end

    // Purpose: ID/EX takes the decoded class or a flush bubble.
    always_ff @(posedge clk) begin
        if (!rst_n)           tail[0] <= '0;
        else if (idex_bubble) tail[0] <= '0;
        else                  tail[0] <= '{v: ifid_v, ldst: ifid_v & id_ldst};
    end

    // Purpose: later slots shift one stage per cycle, never stalled.
    for (genvar i = 1; i < TAIL; i++) begin : g_shift
        always_ff @(posedge clk) begin
            if (!rst_n) tail[i] <= '0;
            else        tail[i] <= tail[i-1];
        end
    end

    assign data_req = tail[MEM_IDX].v & tail[MEM_IDX].ldst;
    assign wb_v     = tail[WB_IDX].v;

    // R4: a bubbled IF/ID holds no valid instruction afterwards.
    assert_bubble_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ifid_bubble |=> !ifid_v);
    // R5: a valid memory-stage slot reaches write-back next cycle.
    assert_mem_to_wb_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tail[MEM_IDX].v |=> wb_v);
    // R8: flush leaves ID/EX empty.
    assert_flush_idex_R8: assert property (@(posedge clk) disable iff (!rst_n)
        idex_bubble |=> !tail[0].v);
endmodule

// File: rtl/ushz_hazard_ctrl.sv
// Module: top of the shared-port structural hazard controller.
// Assumes: decode reports load/store class of its instruction; the
//          datapath applies pc_en / ifid_en / bubbles at the next edge.
module ushz_hazard_ctrl #(
    parameter int TAIL = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fetch_req,
    input  logic id_is_load,
    input  logic id_is_store,
    input  logic flush,
    output logic grant_fetch,
    output logic grant_data,
    output logic addr_sel,
    output logic pc_en,
    output logic ifid_en,
    output logic ifid_bubble,
    output logic idex_bubble,
    output logic fetch_stall,
    output logic wb_valid
);
    logic data_req;
    logic id_ldst;

    assign id_ldst = id_is_load | id_is_store;

    ushz_shadow_pipe #(.TAIL(TAIL)) u_shadow (
        .clk         (clk),
        .rst_n       (rst_n),
        .ifid_bubble (ifid_bubble),
        .idex_bubble (idex_bubble),
        .id_ldst     (id_ldst),
        .data_req    (data_req),
        .wb_v        (wb_valid)
    );

    ushz_port_arb u_arb (
        .data_req    (data_req),
        .fetch_req   (fetch_req),
        .grant_data  (grant_data),
        .grant_fetch (grant_fetch),
        .addr_sel    (addr_sel)
    );

    ushz_stage_ctl u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .grant_fetch (grant_fetch),
        .data_req    (data_req),
        .fetch_req   (fetch_req),
        .flush       (flush),
        .pc_en       (pc_en),
        .ifid_en     (ifid_en),
        .ifid_bubble (ifid_bubble),
        .idex_bubble (idex_bubble),
        .fetch_stall (fetch_stall)
    );

    // R2: the data access owns the port alone.
    assert_data_priority_R2: assert property (@(posedge clk) disable iff (!rst_n)
        grant_data |-> (!grant_fetch && addr_sel));
    // R3: a free port with a fetch request is used by fetch.
    assert_fetch_uses_port_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !grant_data) |-> (grant_fetch && pc_en && !addr_sel));
    // R9: flush beats a coinciding structural stall.
    assert_flush_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && grant_data) |-> (pc_en && idex_bubble && !fetch_stall));
endmodule

// File: tb/test_ushz_hazard_ctrl.sv
module test_ushz_hazard_ctrl;
    logic clk = 1'b0, rst_n = 1'b0;
    logic fetch_req = 1'b0, id_is_load = 1'b0, id_is_store = 1'b0, flush = 1'b0;
    logic grant_fetch, grant_data, addr_sel, pc_en, ifid_en;
    logic ifid_bubble, idex_bubble, fetch_stall, wb_valid;

    int checks = 0, errors = 0, cyc = 0;
    int kind [0:31];   // 0 ALU, 1 load, 2 store
    int fref [0:31];
    int wbc  [0:31];
    int nins, nwb;
    logic fl_pc, fl_gd, fl_ifb, fl_idb, fl_st;

    ushz_hazard_ctrl i_ushz_hazard_ctrl (
        .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req),
        .id_is_load(id_is_load), .id_is_store(id_is_store), .flush(flush),
        .grant_fetch(grant_fetch), .grant_data(grant_data), .addr_sel(addr_sel),
        .pc_en(pc_en), .ifid_en(ifid_en), .ifid_bubble(ifid_bubble),
        .idex_bubble(idex_bubble), .fetch_stall(fetch_stall), .wb_valid(wb_valid)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 60000) begin
            errors++;
            $display("FAIL watchdog R5 actual %0d expected %0d", cyc, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Reference fetch cycles: a fetch may not land three cycles after a data op's fetch.
    function automatic void build_ref();
        int c = 0;
        for (int k = 0; k < nins; k++) begin
            bit blocked;
            do begin
                blocked = 1'b0;
                for (int j = 0; j < k; j++)
                    if (kind[j] != 0 && fref[j] + 3 == c) blocked = 1'b1;
                if (blocked) c++;
            end while (blocked);
            fref[k] = c;
            c++;
        end
    endfunction

    function automatic bit fetch_due(input int c);
        for (int k = 0; k < nins; k++) if (fref[k] == c) return 1'b1;
        return 1'b0;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; fetch_req = 1'b0; flush = 1'b0;
        id_is_load = 1'b0; id_is_store = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check(wb_valid == 1'b0, "R1 wb_valid", wb_valid, 0);
        check(grant_data == 1'b0, "R1 grant_data", grant_data, 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Bench-side pipeline around the controller; cycle 0 begins at reset release.
    task automatic run_seq(input int flush_at, input int ncyc);
        int fetched = 0, id_idx = 0;
        bit id_v = 1'b0;
        nwb = 0;
        for (int c = 0; c < ncyc; c++) begin
            bit got, fl, due;
            fetch_req   = (fetched < nins);
            flush       = (c == flush_at);
            id_is_load  = id_v && kind[id_idx] == 1;
            id_is_store = id_v && kind[id_idx] == 2;
            #1;
            if (wb_valid && nwb < 32) begin wbc[nwb] = c; nwb++; end
            if (flush_at < 0 && fetch_req) begin
                due = fetch_due(c);
                check(grant_fetch == due, "R7 fetch grant timing", grant_fetch, due);
                if (!due) begin
                    check(!pc_en && ifid_bubble && fetch_stall, "R4 stall holds pc", pc_en, 0);
                    check(grant_data && addr_sel, "R2 data owns port", addr_sel, 1);
                end else begin
                    check(pc_en && !addr_sel && !grant_data, "R3 fetch owns port", addr_sel, 0);
                end
            end
            if (c == flush_at) begin
                fl_pc = pc_en; fl_gd = grant_data; fl_ifb = ifid_bubble;
                fl_idb = idex_bubble; fl_st = fetch_stall;
            end
            got = grant_fetch; fl = flush;
            @(negedge clk);
            id_v = got && !fl;
            if (got) begin id_idx = fetched; fetched++; end
        end
        fetch_req = 1'b0; flush = 1'b0; id_is_load = 1'b0; id_is_store = 1'b0;
    endtask

    task automatic check_ref_wb(input string req);
        check(nwb == nins, "R5 retire count", nwb, nins);
        for (int k = 0; k < nins && k < nwb; k++)
            check(wbc[k] == fref[k] + 4, req, wbc[k], fref[k] + 4);
    endtask

    task automatic ref_run(input string req);
        build_ref();
        do_reset();
        run_seq(-1, fref[nins-1] + 8);
    endtask

    initial begin
        int expw [0:7];
        void'($urandom(32'd4242));

        // R6: ALU-only stream, one per cycle.
        nins = 6;
        for (int k = 0; k < nins; k++) kind[k] = 0;
        ref_run("R6");
        check_ref_wb("R6 wb cycle, no data ops");
        for (int k = 1; k < nins; k++)
            check(fref[k] == fref[k-1] + 1, "R6 no stall", fref[k], fref[k-1] + 1);

        // R10: idle front end after drain.
        #1;
        check(!grant_fetch && !pc_en && ifid_bubble && !fetch_stall, "R10 idle", grant_fetch, 0);

        // R7: single load first.
        nins = 5; kind[0] = 1;
        for (int k = 1; k < nins; k++) kind[k] = 0;
        ref_run("R7");
        check_ref_wb("R7 wb cycle, one load");
        check(fref[3] == 4, "R7 one stall", fref[3], 4);

        // R7: back-to-back load, store, load.
        nins = 8; kind[0] = 1; kind[1] = 2; kind[2] = 1;
        for (int k = 3; k < nins; k++) kind[k] = 0;
        ref_run("R7");
        check_ref_wb("R7 wb cycle, back-to-back");

        // R7: every instruction a data op.
        nins = 6;
        for (int k = 0; k < nins; k++) kind[k] = (k % 2) + 1;
        ref_run("R7");
        check_ref_wb("R7 wb cycle, all data ops");

        // R5/R7: random mixes.
        for (int r = 0; r < 6; r++) begin
            nins = 12;
            for (int k = 0; k < nins; k++) kind[k] = $urandom_range(0, 2);
            ref_run("R7");
            check_ref_wb("R5 wb cycle, random mix");
        end

        // R8: flush at cycle 5 on ALU stream drops the instructions fetched in cycles 4 and 5.
        nins = 8;
        for (int k = 0; k < nins; k++) kind[k] = 0;
        do_reset();
        run_seq(5, 14);
        expw = '{4, 5, 6, 7, 10, 11, 0, 0};
        check(nwb == 6, "R8 retire count", nwb, 6);
        for (int k = 0; k < 6 && k < nwb; k++)
            check(wbc[k] == expw[k], "R8 wb cycle after flush", wbc[k], expw[k]);
        check(fl_pc && fl_ifb && fl_idb, "R8 flush controls", fl_idb, 1);

        // R9: flush in the cycle the first load is in memory stage (cycle 3).
        nins = 5; kind[0] = 1;
        for (int k = 1; k < nins; k++) kind[k] = 0;
        do_reset();
        run_seq(3, 12);
        check(fl_pc == 1'b1, "R9 pc_en", fl_pc, 1);
        check(fl_gd == 1'b1, "R9 grant_data", fl_gd, 1);
        check(fl_ifb && fl_idb, "R9 bubbles", fl_idb, 1);
        check(fl_st == 1'b0, "R9 fetch_stall", fl_st, 0);
        expw = '{4, 5, 8, 9, 0, 0, 0, 0};
        check(nwb == 4, "R9 retire count", nwb, 4);
        for (int k = 0; k < 4 && k < nwb; k++)
            check(wbc[k] == expw[k], "R9 wb cycle", wbc[k], expw[k]);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule